// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block runs a whole I2C read or write message on a byte-level I2C master engine that reports its progress through status codes, so no processor needs to handle each event. A client hands over one request: the direction, a 7-bit or 10-bit target address and a byte count. The sequencer then tells the engine to raise START and sends the address byte or bytes. It moves the data bytes and closes the message with STOP. Write bytes come in through a ready/valid stream. Received bytes leave through a valid/data output.

The engine raises a flag whenever it has a new status code. For each flagged status the sequencer makes one decision. That decision depends on the status code, on how many bytes are still to move, and on whether the address is 10-bit. The decision is sent to the engine as a one-cycle command. The command carries control bits (start, stop, acknowledge, bus enable, interrupt enable), an optional byte to load and an optional engine soft reset.

During a read, the acknowledge bit is withdrawn early, so that the engine answers the last byte with a NACK. A zero-length read is a presence probe. A missing target sets a sticky error. Any status code the sequencer does not expect resets the engine.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset the block is idle: req_ready is 1 (while eng_flag is 0), and cmd_valid, done_o, err_o, wr_ready and rd_valid are all 0.
- R2: An accepted request (req_valid with req_ready) produces a command in the next cycle with start=1, ack=1, en=1 and ien equal to IRQ_EN (0 by default). Accepting a request clears err_o.
- R3: On status 0x08 or 0x10 with a 7-bit address, the command loads the byte {addr[6:0], dir}, where dir is 1 for a read.
- R4: With a 10-bit address, status 0x08 or 0x10 loads the byte 0xF0 | addr[9:8]<<1 | dir. Status 0x18 or 0x40 then loads addr[7:0].
- R5: When status 0x28 or 0xD0 (or 0x18 for a 7-bit write) arrives and bytes remain, the block raises wr_ready and issues no command. The cycle after the wr_valid handshake, it issues a command that loads that byte. Write data is taken only in this state.
- R6: On a write, status 0x28 or 0xD0 (or 0x18 for a 7-bit write) with zero bytes remaining causes a STOP command and a one-cycle done_o pulse.
- R7: On a read, the acknowledge bit in each command stays 1 while two or more bytes remain. It becomes 0 in the command issued once only one byte remains.
- R8: Status 0x50 puts eng_rdata on rd_data with a one-cycle rd_valid pulse. Status 0x58 does the same and also issues STOP with done_o.
- R9: A zero-length read issues STOP and done_o directly after status 0x40, with no rd_valid and no error.
- R10: Status 0x20, 0x30 or 0x48 issues STOP with done_o and sets err_o. err_o then holds until the next request is accepted.
- R11: Any other status issues STOP together with an engine soft reset (cmd_srst) and done_o. err_o stays 0.
- R12: A flag seen while idle issues STOP only: done_o and cmd_srst stay 0.
- R13: Every STOP command has start=0 and ien=0.
- R14: Each flag gives at most one command. The flag is ignored in the cycle right after a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Message request offered |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_read | input | 1 | 1 = read message, 0 = write message |
| req_ten | input | 1 | 1 = 10-bit address |
| req_addr | input | 10 | Target address (the low 7 bits in 7-bit mode) |
| req_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte wanted now |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte valid (one cycle) |
| rd_data | output | 8 | Received byte |
| done_o | output | 1 | One-cycle pulse when a message ends with STOP |
| err_o | output | 1 | No-device error, held until the next request |
| eng_flag | input | 1 | Engine has a new status code |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Byte received by the engine |
| cmd_valid | output | 1 | Command to the engine (one cycle) |
| cmd_start | output | 1 | Control: raise START |
| cmd_stop | output | 1 | Control: raise STOP |
| cmd_ack | output | 1 | Control: acknowledge received bytes |
| cmd_en | output | 1 | Control: bus enable |
| cmd_ien | output | 1 | Control: interrupt enable |
| cmd_load | output | 1 | cmd_byte is to be loaded for sending |
| cmd_byte | output | 8 | Byte to send (address or data) |
| cmd_srst | output | 1 | Engine soft reset |

## Verification
A vector table combines both directions, both address widths and both start codes (0x08 and 0x10). This sets apart the address byte formed in each case, and each vector ends with a different not-acknowledged status that must set the sticky error. Directed messages cover the following:
- a two-byte 7-bit write with write data already offered during the address phase, which shows that bytes are pulled only when they are due;
- a 10-bit write and a 10-bit read, which show that the second address byte follows status 0x18 or 0x40;
- a two-byte read, which shows exactly where the acknowledge bit drops;
- a zero-length probe, an unexpected status, a stray flag while idle, and a flag held high past its command.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;

   // engine status codes the sequencer reacts to
   localparam logic [7:0] ST_START   = 8'h08;
   localparam logic [7:0] ST_RSTART  = 8'h10;
   localparam logic [7:0] ST_WA_ACK  = 8'h18;
   localparam logic [7:0] ST_WA_NAK  = 8'h20;
   localparam logic [7:0] ST_WD_ACK  = 8'h28;
   localparam logic [7:0] ST_WD_NAK  = 8'h30;
   localparam logic [7:0] ST_RA_ACK  = 8'h40;
   localparam logic [7:0] ST_RA_NAK  = 8'h48;
   localparam logic [7:0] ST_RD_ACK  = 8'h50;
   localparam logic [7:0] ST_RD_NAK  = 8'h58;
   localparam logic [7:0] ST_WA2_ACK = 8'hD0;
   localparam logic [7:0] ST_RA2_ACK = 8'hE0;

   typedef enum logic [3:0] {
      A_ADDR1, A_ADDR2, A_FEED, A_CONT, A_RCV,
      A_RCV_STOP, A_STOP_OK, A_STOP_NODEV, A_STOP_RESET
   } seq_act_e;

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_FEED} seq_st_e;

   typedef struct packed {
      logic       start;
      logic       stop;
      logic       ack;
      logic       en;
      logic       ien;
      logic       load;
      logic       srst;
      logic [7:0] dat;
   } seq_cmd_t;

endpackage

// File: rtl/i2c_msg_seq_addr.sv
module i2c_msg_seq_addr #(
   parameter bit TEN_EN = 1'b1
) (
   input  logic       rd,
   input  logic       ten,
   input  logic [9:0] addr,
   output logic       ten_eff,
   output logic [7:0] byte1,
   output logic [7:0] byte2
);

   generate
      if (TEN_EN) begin : g_ten
         assign ten_eff = ten;
      end else begin : g_seven
         assign ten_eff = 1'b0;
      end
   endgenerate

   assign byte1 = ten_eff ? {5'b11110, addr[9:8], rd} : {addr[6:0], rd};
   assign byte2 = addr[7:0];

endmodule

// File: rtl/i2c_msg_seq_decode.sv
module i2c_msg_seq_decode
   import i2c_msg_seq_pkg::*;
(
   input  logic [7:0] status,
   input  logic       ten,
   input  logic       left_zero,
   input  logic       left_one,
   input  logic       left_two,
   output seq_act_e   act,
   output logic       clr_ack
);

   always_comb begin
      act     = A_STOP_RESET;
      clr_ack = 1'b0;
      case (status)
         ST_START, ST_RSTART: act = A_ADDR1;
         ST_WA_ACK: begin
            if (ten)            act = A_ADDR2;
            else if (left_zero) act = A_STOP_OK;
            else                act = A_FEED;
         end
         ST_WD_ACK, ST_WA2_ACK: act = left_zero ? A_STOP_OK : A_FEED;
         ST_RA_ACK: begin
            if (ten)            act = A_ADDR2;
            else if (left_zero) act = A_STOP_OK;
            else begin
               act     = A_CONT;
               clr_ack = left_one;
            end
         end
         ST_RA2_ACK: begin
            if (left_zero) act = A_STOP_OK;
            else begin
               act     = A_CONT;
               clr_ack = left_one;
            end
         end
         ST_RD_ACK: begin
            act     = A_RCV;
            clr_ack = left_two;
         end
         ST_RD_NAK:                       act = A_RCV_STOP;
         ST_WA_NAK, ST_WD_NAK, ST_RA_NAK: act = A_STOP_NODEV;
         default:                         act = A_STOP_RESET;
      endcase
   end

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
   import i2c_msg_seq_pkg::*;
#(
   parameter int LEN_W  = 8,
   parameter bit TEN_EN = 1'b1,
   parameter bit IRQ_EN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_read,
   input  logic             req_ten,
   input  logic [9:0]       req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done_o,
   output logic             err_o,
   input  logic             eng_flag,
   input  logic [7:0]       eng_status,
   input  logic [7:0]       eng_rdata,
   output logic             cmd_valid,
   output logic             cmd_start,
   output logic             cmd_stop,
   output logic             cmd_ack,
   output logic             cmd_en,
   output logic             cmd_ien,
   output logic             cmd_load,
   output logic [7:0]       cmd_byte,
   output logic             cmd_srst
);

   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

   generate
      if (LEN_W < 2) begin : g_len_chk
         $error("i2c_msg_seq: LEN_W must be at least 2");
      end
   endgenerate

   seq_st_e          st_q, st_d;
   logic [LEN_W-1:0] left_q, left_d;
   logic             ten_q, ack_q, ack_d, ien_q, ien_d, err_d;
   logic [7:0]       b1_q, b2_q;
   seq_cmd_t         cmd_q, cmd_d;
   logic             cmd_v_d, done_d, rdv_d, store;
   logic             ten_in;
   logic [7:0]       b1_in, b2_in;
   seq_act_e         act;
   logic             clr_ack, act_now;

   i2c_msg_seq_addr #(.TEN_EN(TEN_EN)) u_addr (
      .rd(req_read), .ten(req_ten), .addr(req_addr),
      .ten_eff(ten_in), .byte1(b1_in), .byte2(b2_in)
   );

   i2c_msg_seq_decode u_dec (
      .status(eng_status), .ten(ten_q),
      .left_zero(left_q == '0), .left_one(left_q == LEN_ONE),
      .left_two(left_q == LEN_TWO),
      .act(act), .clr_ack(clr_ack)
   );

   // a command just issued means the engine is still clearing its flag
   assign act_now   = eng_flag && !cmd_valid;
   assign req_ready = (st_q == S_IDLE) && !cmd_valid && !eng_flag;
   assign wr_ready  = (st_q == S_FEED);

   always_comb begin
      st_d    = st_q;
      left_d  = left_q;
      ack_d   = ack_q;
      ien_d   = ien_q;
      err_d   = err_o;
      cmd_d   = '0;
      cmd_v_d = 1'b0;
      done_d  = 1'b0;
      rdv_d   = 1'b0;
      store   = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (act_now) begin
               cmd_v_d    = 1'b1;
               cmd_d.stop = 1'b1;
               cmd_d.ack  = ack_q;
               cmd_d.en   = 1'b1;
               ien_d      = 1'b0;
            end else if (req_valid && req_ready) begin
               store       = 1'b1;
               st_d        = S_RUN;
               left_d      = req_len;
               ack_d       = 1'b1;
               ien_d       = IRQ_EN;
               err_d       = 1'b0;
               cmd_v_d     = 1'b1;
               cmd_d.start = 1'b1;
               cmd_d.ack   = 1'b1;
               cmd_d.en    = 1'b1;
               cmd_d.ien   = IRQ_EN;
            end
         end
         S_RUN: begin
            if (act_now) begin
               ack_d     = ack_q & ~clr_ack;
               cmd_v_d   = 1'b1;
               cmd_d.ack = ack_d;
               cmd_d.en  = 1'b1;
               cmd_d.ien = ien_q;
               case (act)
                  A_ADDR1: begin cmd_d.load = 1'b1; cmd_d.dat = b1_q; end
                  A_ADDR2: begin cmd_d.load = 1'b1; cmd_d.dat = b2_q; end
                  A_FEED:  begin cmd_v_d = 1'b0; st_d = S_FEED; end
                  A_RCV:   begin rdv_d = 1'b1; left_d = left_q - LEN_ONE; end
                  A_RCV_STOP:   rdv_d = 1'b1;
                  A_STOP_NODEV: err_d = 1'b1;
                  A_STOP_RESET: cmd_d.srst = 1'b1;
                  default: ;
               endcase
               if (act inside {A_RCV_STOP, A_STOP_OK, A_STOP_NODEV, A_STOP_RESET}) begin
                  cmd_d.stop = 1'b1;
                  cmd_d.ien  = 1'b0;
                  ien_d      = 1'b0;
                  done_d     = 1'b1;
                  st_d       = S_IDLE;
               end
            end
         end
         S_FEED: begin
            if (wr_valid) begin
               cmd_v_d    = 1'b1;
               cmd_d.load = 1'b1;
               cmd_d.dat  = wr_data;
               cmd_d.ack  = ack_q;
               cmd_d.en   = 1'b1;
               cmd_d.ien  = ien_q;
               left_d     = left_q - LEN_ONE;
               st_d       = S_RUN;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         left_q    <= '0;
         ten_q     <= 1'b0;
         ack_q     <= 1'b1;
         ien_q     <= 1'b0;
         b1_q      <= '0;
         b2_q      <= '0;
         cmd_q     <= '0;
         cmd_valid <= 1'b0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         st_q      <= st_d;
         left_q    <= left_d;
         ack_q     <= ack_d;
         ien_q     <= ien_d;
         cmd_q     <= cmd_d;
         cmd_valid <= cmd_v_d;
         done_o    <= done_d;
         err_o     <= err_d;
         rd_valid  <= rdv_d;
         if (rdv_d) rd_data <= eng_rdata;
         if (store) begin
            ten_q <= ten_in;
            b1_q  <= b1_in;
            b2_q  <= b2_in;
         end
      end
   end

   assign cmd_start = cmd_q.start;
   assign cmd_stop  = cmd_q.stop;
   assign cmd_ack   = cmd_q.ack;
   assign cmd_en    = cmd_q.en;
   assign cmd_ien   = cmd_q.ien;
   assign cmd_load  = cmd_q.load;
   assign cmd_byte  = cmd_q.dat;
   assign cmd_srst  = cmd_q.srst;

endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       wr_valid,
   input logic       wr_ready,
   input logic [7:0] wr_data,
   input logic       done_o,
   input logic       err_o,
   input logic       cmd_valid,
   input logic       cmd_start,
   input logic       cmd_stop,
   input logic       cmd_ien,
   input logic       cmd_load,
   input logic [7:0] cmd_byte,
   input logic       cmd_srst
);

   AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> cmd_valid && cmd_start); // R2
   AST_FEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |=> cmd_valid && cmd_load && cmd_byte == $past(wr_data)); // R5
   AST_DONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> cmd_valid && cmd_stop); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o && cmd_stop); // R10
   AST_SRST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_srst |-> cmd_valid && cmd_stop); // R11
   AST_STOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_stop |-> !cmd_start && !cmd_ien); // R13
   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R14

endmodule

bind i2c_msg_seq i2c_msg_seq_chk u_chk (.*);

// File: tb/test_i2c_msg_seq.sv
module test_i2c_msg_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_read = 1'b0, req_ten = 1'b0;
   logic [9:0] req_addr = '0;
   logic [7:0] req_len = '0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       eng_flag = 1'b0;
   logic [7:0] eng_status = '0, eng_rdata = '0;
   logic       req_ready, wr_ready, rd_valid, done_o, err_o;
   logic [7:0] rd_data, cmd_byte;
   logic       cmd_valid, cmd_start, cmd_stop, cmd_ack, cmd_en, cmd_ien, cmd_load, cmd_srst;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   i2c_msg_seq i_i2c_msg_seq (.*);

   // {read, ten, addr[9:0], start status, expected first address byte}
   localparam int NV = 6;
   localparam logic [27:0] VEC [NV] = '{
      {1'b0, 1'b0, 10'h02A, 8'h08, 8'h54},
      {1'b1, 1'b0, 10'h07F, 8'h10, 8'hFF},
      {1'b0, 1'b1, 10'h3FF, 8'h08, 8'hF6},
      {1'b1, 1'b1, 10'h000, 8'h10, 8'hF1},
      {1'b1, 1'b0, 10'h001, 8'h08, 8'h03},
      {1'b0, 1'b1, 10'h155, 8'h10, 8'hF2}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_req(input logic rd, input logic ten, input logic [9:0] a, input logic [7:0] len);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_read = rd; req_ten = ten; req_addr = a; req_len = len;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 start cmd", {cmd_valid, cmd_start, cmd_ack, cmd_en, cmd_ien}, 5'b11110);
   endtask

   // raise the flag and wait for a command or a write-byte request
   task automatic step(input logic [7:0] st, input logic [7:0] rdat);
      eng_status = st; eng_rdata = rdat; eng_flag = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (cmd_valid || wr_ready) break;
      end
      if (!(cmd_valid || wr_ready)) chk("R14 response", 0, 1);
      if (cmd_valid) eng_flag = 1'b0;
   endtask

   task automatic feed(input logic [7:0] b);
      wr_data = b; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; eng_flag = 1'b0;
      chk("R5 fed byte", {cmd_valid, cmd_load, cmd_byte}, {2'b11, b});
   endtask

   task automatic chk_stop(input string tag, input logic err_exp, input logic srst_exp);
      chk(tag, {cmd_valid, cmd_stop, cmd_start, cmd_ien, done_o, err_o, cmd_srst},
          {4'b1100, 1'b1, err_exp, srst_exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset", {req_ready, cmd_valid, done_o, err_o, wr_ready, rd_valid}, 6'b100000);

      // vector table: address byte forms, ended by a not-acknowledged status (R3, R4, R10)
      for (int v = 0; v < NV; v++) begin
         do_req(VEC[v][27], VEC[v][26], VEC[v][25:16], 8'd1);
         step(VEC[v][15:8], 8'h00);
         chk(VEC[v][26] ? "R4 addr1" : "R3 addr1", {cmd_valid, cmd_load, cmd_byte}, {2'b11, VEC[v][7:0]});
         step(VEC[v][27] ? 8'h48 : 8'h20, 8'h00);
         chk_stop("R10 nodev", 1'b1, 1'b0);
      end
      // R10 error holds until next accept
      repeat (3) @(negedge clk);
      chk("R10 err held", err_o, 1);

      // two-byte 7-bit write with data offered early (R5, R6, R3)
      wr_valid = 1'b1; wr_data = 8'hEE;
      do_req(1'b0, 1'b0, 10'h02A, 8'd2);
      chk("R10 err cleared", err_o, 0);
      chk("R5 no ready early", wr_ready, 0);
      step(8'h08, 8'h00);
      chk("R5 addr not data", {cmd_load, cmd_byte}, {1'b1, 8'h54});
      wr_valid = 1'b0;
      step(8'h18, 8'h00);
      chk("R5 wants byte", {wr_ready, cmd_valid}, 2'b10);
      feed(8'hC3);
      step(8'h28, 8'h00);
      chk("R5 wants byte 2", wr_ready, 1);
      feed(8'h3C);
      step(8'h28, 8'h00);
      chk_stop("R6 R13 write end", 1'b0, 1'b0);

      // 10-bit write with a flag held past its command (R14, R4)
      do_req(1'b0, 1'b1, 10'h2B5, 8'd1);
      eng_status = 8'h08; eng_flag = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (cmd_valid) break;
      end
      chk("R4 ten addr1", {cmd_valid, cmd_byte}, {1'b1, 8'hF4});
      @(negedge clk);
      chk("R14 one cmd per flag", cmd_valid, 0);
      eng_flag = 1'b0;
      step(8'h18, 8'h00);
      chk("R4 ten addr2", {cmd_valid, cmd_load, cmd_byte}, {2'b11, 8'hB5});
      step(8'hD0, 8'h00);
      chk("R5 after D0", wr_ready, 1);
      feed(8'h77);
      step(8'h28, 8'h00);
      chk_stop("R6 ten write end", 1'b0, 1'b0);

      // two-byte 7-bit read (R7, R8)
      do_req(1'b1, 1'b0, 10'h050, 8'd2);
      step(8'h08, 8'h00);
      chk("R3 read addr", cmd_byte, 8'hA1);
      step(8'h40, 8'h00);
      chk("R7 ack kept", {cmd_valid, cmd_load, cmd_ack}, 3'b101);
      step(8'h50, 8'h11);
      chk("R8 byte1", {rd_valid, rd_data}, {1'b1, 8'h11});
      chk("R7 ack dropped", cmd_ack, 0);
      step(8'h58, 8'h22);
      chk("R8 last byte", {rd_valid, rd_data}, {1'b1, 8'h22});
      chk_stop("R8 read stop", 1'b0, 1'b0);

      // 10-bit one-byte read (R4, R7)
      do_req(1'b1, 1'b1, 10'h1C3, 8'd1);
      step(8'h10, 8'h00);
      chk("R4 ten read addr1", cmd_byte, 8'hF3);
      step(8'h40, 8'h00);
      chk("R4 ten read addr2", {cmd_load, cmd_byte}, {1'b1, 8'hC3});
      step(8'hE0, 8'h00);
      chk("R7 single byte nack", {cmd_valid, cmd_load, cmd_ack}, 3'b100);
      step(8'h58, 8'h9E);
      chk("R8 ten read byte", {rd_valid, rd_data}, {1'b1, 8'h9E});

      // zero-length probe (R9)
      do_req(1'b1, 1'b0, 10'h033, 8'd0);
      step(8'h08, 8'h00);
      chk("R9 probe addr", cmd_byte, 8'h67);
      step(8'h40, 8'h00);
      chk_stop("R9 probe stop", 1'b0, 1'b0);
      chk("R9 no data", rd_valid, 0);

      // unexpected status (R11)
      do_req(1'b0, 1'b0, 10'h012, 8'd1);
      step(8'h08, 8'h00);
      step(8'h38, 8'h00);
      chk_stop("R11 bad status", 1'b0, 1'b1);

      // no-device after data (R10)
      do_req(1'b0, 1'b0, 10'h012, 8'd1);
      step(8'h08, 8'h00);
      step(8'h18, 8'h00);
      feed(8'h5A);
      step(8'h30, 8'h00);
      chk_stop("R10 data nak", 1'b1, 1'b0);

      // stray flag while idle (R12)
      repeat (2) @(negedge clk);
      step(8'h28, 8'h00);
      chk("R12 stray stop", {cmd_valid, cmd_stop, done_o, cmd_srst, cmd_ien}, 5'b11000);
      @(negedge clk);
      chk("R12 still idle", req_ready, 1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule